// File: doc/BRIEF.md
# Asynchronous DRAM Burst Page-Mode Controller

This block sequences the row strobe, the column strobe, the multiplexed address and the write-enable of one asynchronous DRAM bank. A simple synchronous request supplies the address, the operand size, the direction and the width of the bank's data port. When the operand is wider than the port, the access is split into several beats. Each beat advances the column by the port width in bytes, and all beats stay in one DRAM row.

Several static fields shape each access: the row-to-column delay, the column-strobe width, the row-strobe precharge time, the choice of dropping the row strobe one clock after the column strobe, and the page mode. In burst page mode the row strobe stays active for the whole burst and only the column strobe is pulsed for each beat. In any other mode each beat is a complete row cycle. The precharge rule can hold off the row strobe of a following cycle, but it never holds off the row address shown on the address pins.

Top module: `dram_burst_ctrl`

## Requirements
- R1: While reset is active, and in the first clock after it, `ras_on`, `cas_on`, `xfer_ack`, `xfer_done` and `dram_we` are low and `req_ready` is high.
- R2: After `ras_on` rises, it stays high for `cfg_rcd`+1 clocks before `cas_on` rises. `dram_addr` carries the row (request address bits [AW-1:CW]) in the first of these clocks and the column in the rest.
- R3: `cas_on` stays high for `cfg_cas`+1 clocks for each beat. `xfer_ack` is high only in the last of these clocks, so there is exactly one `xfer_ack` per beat.
- R4: When `cfg_rncn`=0, `ras_on` falls on the same edge as `cas_on` after the final beat. When `cfg_rncn`=1, it falls one clock later.
- R5: `ras_on` stays low for at least `cfg_rp`+1 consecutive clocks. A request that arrives too early enters a wait in which `ras_on` is low and `dram_addr` already shows the row. `ras_on` rises as soon as the count is met.
- R6: The beat count is max(1, operand bytes / port bytes). `req_size` 0, 1, 2 and 3 mean 1, 2, 4 and 16 bytes. `port_sz` 0, 1 and 2 mean 8, 16 and 32 bits, and code 3 is treated as 32 bits.
- R7: With `cfg_pm`=2'b01 and more than one beat, `ras_on` stays high between beats. Between two beats there is exactly one clock with `cas_on` low, and in that clock `dram_addr` already shows the next column.
- R8: The column advances by the port width in bytes after every beat, wrapping within CW bits. The row never changes during an access.
- R9: With `cfg_pm` other than 2'b01, every beat is a full row cycle: row address, `cfg_rcd`+1 row clocks and the column strobe. Consecutive beats are separated by a precharge that obeys R5.
- R10: A single-beat access produces the same output waveform in burst page mode as in non-page mode.
- R11: `xfer_done` is a one-clock pulse in the clock after `ras_on` falls for the last time. `req_ready` is low from the accepting edge through that pulse and is high again in the next clock.
- R12: `dram_we` equals the request's write flag from acceptance until `xfer_done`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; accepted on an edge where `req_ready` is high |
| req_addr | input | AW | Byte address: row in the upper AW-CW bits, column in the lower CW bits |
| req_size | input | 2 | Operand size code (byte, word, longword, 16-byte line) |
| req_write | input | 1 | 1 for a write, 0 for a read |
| port_sz | input | 2 | Bank data port width code |
| cfg_rcd | input | TW | Row-to-column delay minus one |
| cfg_cas | input | TW | Column-strobe width minus one |
| cfg_rp | input | TW | Row precharge clocks minus one |
| cfg_rncn | input | 1 | Drop the row strobe one clock after the column strobe |
| cfg_pm | input | 2 | Page mode; 2'b01 selects burst page mode |
| req_ready | output | 1 | Idle and able to accept a request |
| ras_on | output | 1 | Row strobe active (active high at this boundary) |
| cas_on | output | 1 | Column strobe active (active high at this boundary) |
| dram_addr | output | MW | Multiplexed row/column address |
| dram_we | output | 1 | Write enable for the current access |
| xfer_ack | output | 1 | One pulse per beat, in the last column-strobe clock |
| xfer_done | output | 1 | One pulse after the final beat |

## Verification
All results are fixed by the request's accepting edge. The first row clock is the clock after that edge. The column strobe follows `cfg_rcd`+1 clocks later, and `xfer_ack` comes `cfg_cas` clocks after that. In page mode each following beat starts `cfg_cas`+2 clocks after the previous one. `xfer_done` comes one clock after the last strobe falls, or two clocks after it when `cfg_rncn`=1. The bench builds this schedule from the configuration, with wait clocks counted from R5. It then compares every output once per clock, on the falling edge, so no check runs on the edge where an output changes.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

  localparam int BEAT_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ROW, ST_COL, ST_GAP, ST_TAIL, ST_DONE
  } seq_state_t;

  // log2 of the port width in bytes; code 3 is clamped to 32 bits
  function automatic logic [2:0] port_lg(input logic [1:0] code);
    return (code == 2'd3) ? 3'd2 : {1'b0, code};
  endfunction

  // log2 of the operand size in bytes; code 3 is a 16-byte line
  function automatic logic [2:0] oper_lg(input logic [1:0] code);
    return (code == 2'd3) ? 3'd4 : {1'b0, code};
  endfunction

  function automatic logic [BEAT_W-1:0] beat_count(input logic [1:0] size_code,
                                                   input logic [1:0] port_code);
    logic [2:0] o, p;
    o = oper_lg(size_code);
    p = port_lg(port_code);
    if (o > p) return BEAT_W'(5'd1 << (o - p));
    return BEAT_W'(1);
  endfunction

  function automatic logic [2:0] col_step(input logic [1:0] port_code);
    return 3'(3'd1 << port_lg(port_code));
  endfunction

endpackage

// File: rtl/dbc_precharge.sv
module dbc_precharge #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ras_on,
  input  logic [TW-1:0] cfg_rp,
  output logic          pre_ok
);
  localparam logic [TW-1:0] CMAX = {TW{1'b1}};

  // completed consecutive clocks with the row strobe low
  logic [TW-1:0] neg_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          neg_cnt <= CMAX;
    else if (ras_on)     neg_cnt <= '0;
    else if (neg_cnt != CMAX) neg_cnt <= neg_cnt + 1'b1;
  end

  // counting the present low clock, cfg_rp+1 clocks are reached
  assign pre_ok = !ras_on && (neg_cnt >= cfg_rp);

endmodule

// File: rtl/dbc_addr.sv
module dbc_addr #(
  parameter int AW = 20,
  parameter int CW = 10,
  parameter int MW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    port_sz,
  input  logic          col_adv,
  input  logic          sel_row,
  output logic [MW-1:0] dram_addr
);
  import dbc_pkg::*;

  localparam int RW = AW - CW;

  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [CW-1:0] step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      row_q  <= req_addr[AW-1:CW];
      col_q  <= req_addr[CW-1:0];
      step_q <= CW'(col_step(port_sz));
    end else if (col_adv) begin
      col_q  <= col_q + step_q;
    end
  end

  assign dram_addr = sel_row ? MW'(row_q) : MW'(col_q);

  a_r8_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(row_q));

endmodule

// File: rtl/dbc_seq.sv
module dbc_seq #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [1:0]    port_sz,
  input  logic [TW-1:0] cfg_rcd,
  input  logic [TW-1:0] cfg_cas,
  input  logic          cfg_rncn,
  input  logic [1:0]    cfg_pm,
  input  logic          pre_ok,
  output logic          req_ready,
  output logic          load,
  output logic          ras_on,
  output logic          cas_on,
  output logic          xfer_ack,
  output logic          xfer_done,
  output logic          dram_we,
  output logic          col_adv,
  output logic          sel_row
);
  import dbc_pkg::*;

  seq_state_t        state;
  logic [TW-1:0]     tcnt;
  logic [BEAT_W-1:0] beats_left;
  logic              wr_q;
  logic              page_mode;
  logic              last_beat;

  assign page_mode = (cfg_pm == 2'b01);
  assign last_beat = (beats_left == BEAT_W'(1));
  assign req_ready = (state == ST_IDLE);
  assign load      = req_ready && req_valid;
  assign ras_on    = (state == ST_ROW) || (state == ST_COL) ||
                     (state == ST_GAP) || (state == ST_TAIL);
  assign cas_on    = (state == ST_COL);
  assign xfer_ack  = (state == ST_COL) && (tcnt == cfg_cas);
  assign col_adv   = xfer_ack;
  assign xfer_done = (state == ST_DONE);
  assign dram_we   = wr_q && (state != ST_IDLE) && (state != ST_DONE);
  assign sel_row   = (state == ST_IDLE) || (state == ST_WAIT) ||
                     (state == ST_DONE) || ((state == ST_ROW) && (tcnt == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tcnt       <= '0;
      beats_left <= '0;
      wr_q       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          beats_left <= beat_count(req_size, port_sz);
          wr_q       <= req_write;
          tcnt       <= '0;
          state      <= pre_ok ? ST_ROW : ST_WAIT;
        end
        ST_WAIT: if (pre_ok) begin
          tcnt  <= '0;
          state <= ST_ROW;
        end
        ST_ROW: if (tcnt == cfg_rcd) begin
          tcnt  <= '0;
          state <= ST_COL;
        end else tcnt <= tcnt + 1'b1;
        ST_COL: if (tcnt == cfg_cas) begin
          tcnt       <= '0;
          beats_left <= beats_left - 1'b1;
          if (last_beat)      state <= cfg_rncn ? ST_TAIL : ST_DONE;
          else if (page_mode) state <= ST_GAP;
          else                state <= cfg_rncn ? ST_TAIL : ST_WAIT;
        end else tcnt <= tcnt + 1'b1;
        ST_GAP:  state <= ST_COL;
        ST_TAIL: state <= (beats_left == '0) ? ST_DONE : ST_WAIT;
        ST_DONE: begin
          wr_q  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_on) |-> $past(ras_on));
  a_r3_cas_drops_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |=> !cas_on);
  a_r7_ras_kept_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_ack && !last_beat && page_mode) |=> (ras_on && !cas_on));
  a_r11_done_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> (!xfer_done && req_ready));

endmodule

// File: rtl/dram_burst_ctrl.sv
module dram_burst_ctrl #(
  parameter int AW = 20,
  parameter int CW = 10,
  parameter int TW = 2,
  parameter int MW = ((AW - CW) > CW) ? (AW - CW) : CW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          req_write,
  input  logic [1:0]    port_sz,
  input  logic [TW-1:0] cfg_rcd,
  input  logic [TW-1:0] cfg_cas,
  input  logic [TW-1:0] cfg_rp,
  input  logic          cfg_rncn,
  input  logic [1:0]    cfg_pm,
  output logic          req_ready,
  output logic          ras_on,
  output logic          cas_on,
  output logic [MW-1:0] dram_addr,
  output logic          dram_we,
  output logic          xfer_ack,
  output logic          xfer_done
);
  logic pre_ok;
  logic load;
  logic col_adv;
  logic sel_row;

  dbc_precharge #(.TW(TW)) u_pre (
    .clk(clk), .rst_n(rst_n), .ras_on(ras_on), .cfg_rp(cfg_rp), .pre_ok(pre_ok)
  );

  dbc_seq #(.TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_write(req_write), .port_sz(port_sz), .cfg_rcd(cfg_rcd),
    .cfg_cas(cfg_cas), .cfg_rncn(cfg_rncn), .cfg_pm(cfg_pm), .pre_ok(pre_ok),
    .req_ready(req_ready), .load(load), .ras_on(ras_on), .cas_on(cas_on),
    .xfer_ack(xfer_ack), .xfer_done(xfer_done), .dram_we(dram_we),
    .col_adv(col_adv), .sel_row(sel_row)
  );

  dbc_addr #(.AW(AW), .CW(CW), .MW(MW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .req_addr(req_addr),
    .port_sz(port_sz), .col_adv(col_adv), .sel_row(sel_row),
    .dram_addr(dram_addr)
  );

  a_r5_precharge_met: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_on) |-> $past(pre_ok));
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r4_cas_within_ras: assert property (@(posedge clk) disable iff (!rst_n)
    cas_on |-> ras_on);

endmodule

// File: tb/dram_burst_ctrl_tb_top.sv
module dram_burst_ctrl_tb_top;
  localparam int AW = 20;
  localparam int CW = 10;
  localparam int TW = 2;
  localparam int MW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_write = 1'b0;
  logic [1:0]    port_sz = '0;
  logic [TW-1:0] cfg_rcd = '0;
  logic [TW-1:0] cfg_cas = '0;
  logic [TW-1:0] cfg_rp = '0;
  logic          cfg_rncn = 1'b0;
  logic [1:0]    cfg_pm = '0;
  logic          req_ready, ras_on, cas_on, dram_we, xfer_ack, xfer_done;
  logic [MW-1:0] dram_addr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dram_burst_ctrl #(.AW(AW), .CW(CW), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .port_sz(port_sz),
    .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas), .cfg_rp(cfg_rp), .cfg_rncn(cfg_rncn),
    .cfg_pm(cfg_pm), .req_ready(req_ready), .ras_on(ras_on), .cas_on(cas_on),
    .dram_addr(dram_addr), .dram_we(dram_we), .xfer_ack(xfer_ack),
    .xfer_done(xfer_done)
  );

  // compare one clock: {ready, ras, cas, ack, done, we} plus address when asked
  task automatic chk(input logic [5:0] exp, input bit use_addr,
                     input logic [MW-1:0] exp_addr, input string tag);
    logic [5:0] act;
    act = {req_ready, ras_on, cas_on, xfer_ack, xfer_done, dram_we};
    total++;
    if (act !== exp || (use_addr && dram_addr !== exp_addr)) begin
      bad++;
      $display("FAIL %s t=%0t rdy/ras/cas/ack/done/we act=%b exp=%b addr act=%h exp=%h",
               tag, $time, act, exp, dram_addr, exp_addr);
    end
  endtask

  task automatic cyc(input logic [5:0] exp, input bit use_addr,
                     input logic [MW-1:0] exp_addr, input string tag);
    chk(exp, use_addr, exp_addr, tag);
    @(negedge clk);
  endtask

  function automatic int exp_beats(input logic [1:0] s, input logic [1:0] p);
    int ob, pb;
    ob = (s == 2'd3) ? 16 : (1 << s);
    pb = (p == 2'd0) ? 1 : (p == 2'd1) ? 2 : 4;
    return (ob > pb) ? ob / pb : 1;
  endfunction

  function automatic int port_bytes(input logic [1:0] p);
    return (p == 2'd0) ? 1 : (p == 2'd1) ? 2 : 4;
  endfunction

  // Issue one request and walk its whole expected schedule; returns at the
  // falling edge inside the done clock. w0 = wait clocks before the first RAS.
  task automatic access(input logic [AW-1:0] a, input logic [1:0] s,
                        input logic wr, input logic [1:0] p,
                        input int rcd, input int cw, input int rp,
                        input logic rncn, input logic [1:0] pm,
                        input int w0, input string ttag);
    int nb, pb, nw;
    logic [MW-1:0] row, colb;
    bit page;
    req_addr = a; req_size = s; req_write = wr; port_sz = p;
    cfg_rcd = TW'(rcd); cfg_cas = TW'(cw); cfg_rp = TW'(rp);
    cfg_rncn = rncn; cfg_pm = pm;
    req_valid = 1'b1;
    while (req_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    nb = exp_beats(s, p);
    pb = port_bytes(p);
    page = (pm == 2'b01);
    row = a[AW-1:CW];
    for (int b = 0; b < nb; b++) begin
      colb = MW'(a[CW-1:0] + CW'(b * pb));
      if (b == 0 || !page) begin
        nw = (b == 0) ? w0 : rp + 1;
        for (int i = 0; i < nw; i++) cyc({5'b00000, wr}, 1'b1, row, {"R5 ", ttag});
        for (int i = 0; i <= rcd; i++)
          cyc({5'b01000, wr}, 1'b1, (i == 0) ? row : colb, {"R2 ", ttag});
      end
      for (int i = 0; i <= cw; i++)
        cyc({3'b011, (i == cw), 1'b0, wr}, 1'b1, colb, {"R3 ", ttag});
      if (b < nb - 1 && page)
        cyc({5'b01000, wr}, 1'b1, MW'(colb + MW'(pb)), {"R7 ", ttag});
      else if (rncn)
        cyc({5'b01000, wr}, 1'b0, '0, {"R4 ", ttag});
    end
    chk(6'b000010, 1'b0, '0, {"R11 ", ttag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(6'b100000, 1'b0, '0, "R11 ready after done");
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(6'b100000, 1'b0, '0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(6'b100000, 1'b0, '0, "R1 after reset");
  endtask

  task automatic t_single_modes;
    // longword, 32-bit port: one beat; non-page then page mode must match
    access(20'h2A_345, 2'd2, 1'b0, 2'd2, 1, 1, 1, 1'b0, 2'b00, 0, "R12 single read");
    idle(4);
    access(20'h2A_345, 2'd2, 1'b0, 2'd2, 1, 1, 1, 1'b0, 2'b01, 0, "R10 single page");
    idle(4);
    access(20'h15_0F0, 2'd0, 1'b1, 2'd2, 0, 2, 0, 1'b1, 2'b01, 0, "R6 byte one beat");
    idle(4);
    access(20'h15_0F0, 2'd1, 1'b0, 2'd1, 2, 0, 0, 1'b0, 2'b01, 0, "R6 word one beat");
    idle(4);
  endtask

  task automatic t_page_bursts;
    access(20'h33_010, 2'd2, 1'b1, 2'd0, 0, 0, 0, 1'b1, 2'b01, 0, "R7 R8 R12 long to 8bit");
    idle(4);
    access(20'h07_100, 2'd3, 1'b0, 2'd2, 2, 2, 0, 1'b0, 2'b01, 0, "R8 line to 32bit");
    idle(4);
    access(20'h01_200, 2'd3, 1'b1, 2'd0, 0, 0, 0, 1'b0, 2'b01, 0, "R6 line to 8bit 16 beats");
    idle(4);
    access(20'h3F_3F8, 2'd3, 1'b0, 2'd3, 1, 0, 0, 1'b1, 2'b01, 0, "R6 R8 port code 3 wrap");
    idle(4);
  endtask

  task automatic t_nonpage_burst;
    access(20'h0C_040, 2'd1, 1'b0, 2'd0, 1, 1, 1, 1'b1, 2'b00, 0, "R9 word to 8bit");
    idle(4);
    access(20'h0C_080, 2'd2, 1'b1, 2'd1, 0, 0, 2, 1'b0, 2'b10, 0, "R9 long to 16bit");
    idle(4);
  endtask

  task automatic t_back_to_back;
    access(20'h11_111, 2'd2, 1'b0, 2'd2, 0, 0, 3, 1'b0, 2'b00, 0, "R5 first");
    // done and accept clocks give 2 low clocks; 4 needed -> 2 wait clocks
    access(20'h22_222, 2'd2, 1'b1, 2'd2, 0, 0, 3, 1'b0, 2'b00, 2, "R5 held off");
    // rp=1 needs 2 low clocks, already met -> no wait
    access(20'h23_200, 2'd2, 1'b0, 2'd2, 0, 1, 1, 1'b0, 2'b00, 0, "R5 met");
    idle(2);
  endtask

  initial begin
    t_reset();
    t_single_modes();
    t_page_bursts();
    t_nonpage_burst();
    t_back_to_back();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule